// File: doc/BRIEF.md
# Local Wakeup Contact Filter and Edge Detector

This block is the digital side of a slow wakeup input that watches an external switch or contact. It brings the raw comparator output into the clock domain and debounces it: a level counts only after it has held for a set number of cycles. The debounced level picks which of two bias current sources the analog front end turns on, so an open input is held in the state it last settled in. The current sources themselves are outside the block, which drives only their enables.

The debounced level is shown on a status output while the chip is in an active mode. A 2-bit field chooses which transitions of the debounced level count as events: rising, falling, both, or none. A selected transition sets a flag that stays set until software clears it. In the same cycle the block sends a one-cycle request to the mode controller. That request is an interrupt request in active modes and a wakeup request in sleep. If the chip sleeps with no other wakeup source armed, the block watches both edges whatever the field says, so the chip can always be woken.

Top module: `wake_input_filter`

## Requirements
- R1: During reset and after it, the debounced level is low, the pull-down enable is high and the pull-up enable is low, and the wake flag, interrupt request and wakeup request are all low.
- R2: The raw input passes through SYNC_STAGES flip-flops. The debounced level goes high, with the pull-up enable high and the pull-down enable low, at the clock edge where the synchronized input has differed from the debounced level for FILT_CYCLES edges in a row. With the defaults this is the (FILT_CYCLES+2)th edge, counting the first edge that samples the new raw level.
- R3: A stable low input clears the debounced level with the same timing as R2 and turns the pull-down enable on and the pull-up enable off.
- R4: If the synchronized input returns before FILT_CYCLES edges have passed, the debounced level and both bias enables stay as they were, and the run count restarts.
- R5: level_stat equals the debounced level while active_mode is high and reads 0 otherwise.
- R6: The edge_mode field selects which debounced transitions are events: 00 none, 01 low-to-high, 10 high-to-low, 11 both.
- R7: A selected event sets wake_flag at the same edge where the debounced level changes. wake_flag stays set until a clock edge where flag_clr is high. An event at the same edge as flag_clr leaves the flag set.
- R8: A selected event gives a one-cycle irq_req pulse when active_mode is high, or a one-cycle wake_req pulse when sleep_mode is high. Both pulses appear at the edge where the flag sets.
- R9: While sleep_mode is high and other_wake_en is low, both edges count as events, whatever the value of edge_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | 1 | Raw comparator output of the wakeup contact |
| edge_mode | input | 2 | Event edge select (00 none, 01 rise, 10 fall, 11 both) |
| active_mode | input | 1 | Chip is in an active operating mode |
| sleep_mode | input | 1 | Chip is in sleep |
| other_wake_en | input | 1 | Some other wakeup source is armed |
| flag_clr | input | 1 | Read-and-clear strobe for the wake flag |
| bias_pu_en | output | 1 | Enable of the pull-up bias current |
| bias_pd_en | output | 1 | Enable of the pull-down bias current |
| level_stat | output | 1 | Debounced level, valid in active modes |
| wake_flag | output | 1 | Sticky wake event flag |
| irq_req | output | 1 | One-cycle event pulse in active modes |
| wake_req | output | 1 | One-cycle event pulse in sleep |

## Verification
The input is driven with random run lengths from one cycle up to about twice the debounce window. Runs just shorter than the window and runs exactly as long as it are included, which separates an off-by-one in the debounce count from a correct filter. Each of the four edge_mode values is tried in active, sleep and idle modes, with other_wake_en both set and clear. This separates a wrong edge encoding from a wrong sleep override. A clear strobe is held across the edge where an event lands, which shows whether a new event wins over the clear.

// File: rtl/wake_input_filter.sv
module wake_input_filter #(
  parameter int FILT_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_raw,
  input  logic [1:0] edge_mode,
  input  logic       active_mode,
  input  logic       sleep_mode,
  input  logic       other_wake_en,
  input  logic       flag_clr,
  output logic       bias_pu_en,
  output logic       bias_pd_en,
  output logic       level_stat,
  output logic       wake_flag,
  output logic       irq_req,
  output logic       wake_req
);

  localparam int CNT_W = $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       run_cnt;
  logic                   filt_q;
  logic                   flag_q, irq_q, wake_q;

  wire sync_in  = sync_q[SYNC_STAGES-1];
  wire differs  = sync_in != filt_q;
  wire flip     = differs && (run_cnt == CNT_LAST);
  wire force_both = sleep_mode && !other_wake_en;
  wire [1:0] eff_mode = force_both ? 2'b11 : edge_mode;
  wire hit = flip && ((!filt_q && eff_mode[0]) || (filt_q && eff_mode[1]));

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      filt_q  <= 1'b0;
    end else if (!differs) begin
      run_cnt <= '0;
    end else if (flip) begin
      run_cnt <= '0;
      filt_q  <= sync_in;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      flag_q <= hit || (flag_q && !flag_clr);
      irq_q  <= hit && active_mode;
      wake_q <= hit && sleep_mode;
    end
  end

  assign bias_pu_en = filt_q;
  assign bias_pd_en = !filt_q;
  assign level_stat = active_mode && filt_q;
  assign wake_flag  = flag_q;
  assign irq_req    = irq_q;
  assign wake_req   = wake_q;

  a_r2_flip_needs_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(run_cnt) == CNT_LAST));

  a_r3_flip_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(sync_in)));

  a_r4_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in == filt_q) |=> (run_cnt == '0));

  a_r7_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> wake_flag);

  a_r7_flag_falls_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_flag) |-> $past(flag_clr));

  a_r8_irq_in_active: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($past(active_mode) && wake_flag));

  a_r8_wake_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ($past(sleep_mode) && wake_flag));

  a_r9_forced_both: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && sleep_mode && !other_wake_en) |=> wake_flag);

endmodule

// File: tb/wake_input_filter_tb_top.sv
module wake_input_filter_tb_top;
  localparam int FILT = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic pin_raw = 0;
  logic [1:0] edge_mode = 2'b00;
  logic active_mode = 0, sleep_mode = 0, other_wake_en = 0, flag_clr = 0;
  logic bias_pu_en, bias_pd_en, level_stat, wake_flag, irq_req, wake_req;

  int vectors = 0;
  int fails = 0;
  bit cmp_en = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wake_input_filter #(.FILT_CYCLES(FILT), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .edge_mode(edge_mode),
    .active_mode(active_mode), .sleep_mode(sleep_mode),
    .other_wake_en(other_wake_en), .flag_clr(flag_clr),
    .bias_pu_en(bias_pu_en), .bias_pd_en(bias_pd_en), .level_stat(level_stat),
    .wake_flag(wake_flag), .irq_req(irq_req), .wake_req(wake_req));

  logic m_s1, m_s2, m_lvl, m_flag, m_irq, m_wake;
  int   m_run;

  function automatic logic sel_edge(logic rising, logic [1:0] md, logic slp, logic oth);
    logic [1:0] e;
    e = (slp && !oth) ? 2'b11 : md;
    return rising ? e[0] : e[1];
  endfunction

  always @(posedge clk) begin
    logic hit;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_flag = 0; m_irq = 0; m_wake = 0; m_run = 0;
    end else begin
      hit = 0;
      if (m_s2 != m_lvl) begin
        m_run++;
        if (m_run == FILT) begin
          hit = sel_edge(m_s2, edge_mode, sleep_mode, other_wake_en);
          m_lvl = m_s2;
          m_run = 0;
        end
      end else m_run = 0;
      m_flag = hit || (m_flag && !flag_clr);
      m_irq  = hit && active_mode;
      m_wake = hit && sleep_mode;
      m_s2 = m_s1;
      m_s1 = pin_raw;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    chk("R2/R3 bias_pu_en", bias_pu_en, m_lvl);
    chk("R2/R3 bias_pd_en", bias_pd_en, !m_lvl);
    chk("R5 level_stat", level_stat, active_mode && m_lvl);
    chk("R7 wake_flag", wake_flag, m_flag);
    chk("R8 irq_req", irq_req, m_irq);
    chk("R8 wake_req", wake_req, m_wake);
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr = 1; cyc(1); flag_clr = 0;
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    cyc(3);
    chk("R1 reset pd", bias_pd_en, 1'b1);
    chk("R1 reset pu", bias_pu_en, 1'b0);
    chk("R1 reset flag", wake_flag, 1'b0);
    rst_n = 1;
    cyc(1);
    cmp_en = 1;
    chk("R1 after reset level", bias_pu_en, 1'b0);

    // R4: a pulse one cycle short of the window is ignored
    active_mode = 1; edge_mode = 2'b11;
    pin_raw = 1; cyc(FILT - 1); pin_raw = 0; cyc(FILT + 4);
    chk("R4 short pulse level", level_stat, 1'b0);
    chk("R4 short pulse bias", bias_pd_en, 1'b1);
    chk("R4 short pulse flag", wake_flag, 1'b0);

    // R2: exact window length accepted
    pin_raw = 1; cyc(FILT + 1);
    chk("R2 not yet high", level_stat, 1'b0);
    cyc(1);
    chk("R2 high after window", level_stat, 1'b1);
    chk("R6 both edges rising flag", wake_flag, 1'b1);
    clear_flag();

    // R6: mode 00 ignores edges
    edge_mode = 2'b00;
    pin_raw = 0; cyc(FILT + 4);
    chk("R3 low after window", bias_pd_en, 1'b1);
    chk("R6 mode 00 no flag", wake_flag, 1'b0);

    // R6: falling only ignores a rising edge
    edge_mode = 2'b10;
    pin_raw = 1; cyc(FILT + 4);
    chk("R6 mode 10 ignores rise", wake_flag, 1'b0);
    pin_raw = 0; cyc(FILT + 4);
    chk("R6 mode 10 takes fall", wake_flag, 1'b1);
    clear_flag();

    // R7: event on the same edge as the clear keeps the flag
    edge_mode = 2'b01;
    flag_clr = 1;
    pin_raw = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq_req) begin
        chk("R7 event beats clear", wake_flag, 1'b1);
        break;
      end
    end
    @(negedge clk);
    chk("R7 cleared next cycle", wake_flag, 1'b0);
    flag_clr = 0;

    // R9: sleep with no other source forces both edges
    active_mode = 0; sleep_mode = 1; other_wake_en = 0; edge_mode = 2'b00;
    pin_raw = 0; cyc(FILT + 4);
    chk("R9 forced both edges", wake_flag, 1'b1);
    chk("R5 status hidden outside active", level_stat, 1'b0);
    clear_flag();
    other_wake_en = 1;
    pin_raw = 1; cyc(FILT + 4);
    chk("R9 no force with other source", wake_flag, 1'b0);
    sleep_mode = 0; other_wake_en = 0;

    // random phase
    for (int seg = 0; seg < 120; seg++) begin
      int unsigned m;
      m = $urandom_range(0, 2);
      active_mode = (m == 0);
      sleep_mode = (m == 1);
      other_wake_en = $urandom_range(0, 1);
      edge_mode = 2'($urandom_range(0, 3));
      for (int r = 0; r < 6; r++) begin
        pin_raw = ~pin_raw;
        for (int k = 0; k < int'($urandom_range(1, 2 * FILT + 2)); k++) begin
          flag_clr = ($urandom_range(0, 9) == 0);
          cyc(1);
        end
      end
      flag_clr = 0;
    end
    cyc(5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule